// File: doc/BRIEF.md
# Bus Alert Line Controller

This block runs the shared, active-low alert wire of a system-management bus. One enable input is read in two ways, depending on a role input. In device role, enabling pulls the wire low to request attention from the host. It also enables matching of the alert response address, so the device can answer the host's query. In host role, the same enable arms a falling-edge detector on the wire. That detector sets a sticky flag, which can raise an interrupt.

The raw pin level passes through a synchronizer whose depth is a parameter (two flops by default) before any edge is detected. While the detector is not armed, the wire counts as idle-high internally, whatever level the pin has. Edge detection compares consecutive synchronized samples, so arming while the wire is already low does not produce a false event. The flag holds until the clear input is pulsed. The pull-low request is purely combinational, so it drops in the same cycle that the enable drops.

Top module: `alert_line_ctrl`

## Requirements
- R1: In device role (role input 0) with the enable at 1, pull_low_o is 1; it returns to 0 combinationally in the same cycle the enable goes to 0.
- R2: ara_en_o is 1 exactly when the role input is 0 and the enable is 1.
- R3: In host role (role input 1) with the enable at 1, a high-to-low transition on alert_pin_i sets alert_flag_o; with the pin changed between clock edges, the flag is still 0 after the second following rising edge and is 1 after the third.
- R4: irq_o equals alert_flag_o AND err_irq_en_i.
- R5: With the enable at 0, or in device role, a falling pin never sets alert_flag_o, because the internal wire level is taken as high.
- R6: In host role, or with the enable at 0, pull_low_o is 0, leaving the pin free for other use.
- R7: alert_flag_o stays at 1 until flag_clr_i is sampled at 1 on a rising edge, and is 0 after that edge; a new edge event in the same cycle as a clear wins and leaves the flag set.
- R8: Arming host detection while the synchronized pin is already low does not set the flag.
- R9: During and just after reset, with the enable at 0, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode_i | input | 1 | Role: 0 device, 1 host |
| alert_en_i | input | 1 | Alert enable (drive low in device role, arm detection in host role) |
| err_irq_en_i | input | 1 | Interrupt enable for the alert flag |
| alert_pin_i | input | 1 | Raw level of the alert wire |
| flag_clr_i | input | 1 | Clears the alert flag on a rising edge |
| pull_low_o | output | 1 | Request to pull the open-drain wire low |
| ara_en_o | output | 1 | Enable for alert response address matching |
| alert_flag_o | output | 1 | Sticky alert event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the role gating of the pull-low request and of the address-match enable, the interrupt gating, and that the flag only rises after a cycle in which host detection was armed. They also check that the flag holds when no clear is given, that a clear without an event empties it, and that an event always leaves it set. The exact three-edge latency through the synchronizer, and the absence of a flag when detection is armed on an already-low wire, can only be shown by the bench. It shows them by driving timed pin sequences across every combination of role, enable and interrupt enable.

// File: rtl/alert_pkg.sv
package alert_pkg;
  typedef enum logic {
    ROLE_DEVICE = 1'b0,
    ROLE_HOST   = 1'b1
  } role_e;

  localparam logic LINE_IDLE = 1'b1;
endpackage

// File: rtl/alert_sync.sv
module alert_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  import alert_pkg::*;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb chain_d[s] = d_i;
      end else begin : g_rest
        always_comb chain_d[s] = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= LINE_IDLE;
        else        chain_q[s] <= chain_d[s];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/alert_fall_det.sv
module alert_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic lvl_i,
  output logic fall_o
);
  import alert_pkg::*;

  logic prev_q;
  logic prev_d;
  logic line_eff;

  // Disarmed: the wire counts as idle-high internally.
  always_comb begin
    line_eff = arm_i ? lvl_i : LINE_IDLE;
    prev_d   = lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= LINE_IDLE;
    else        prev_q <= prev_d;
  end

  // The previous sample is the raw synchronized level, so arming on a
  // wire that is already low sees no transition.
  assign fall_o = arm_i & prev_q & ~line_eff;
endmodule

// File: rtl/alert_flag_reg.sv
module alert_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_ce;

  always_comb begin
    flag_ce = set_i | clr_i;
    flag_d  = set_i;            // set wins over a simultaneous clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/alert_line_ctrl.sv
module alert_line_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_mode_i,
  input  logic alert_en_i,
  input  logic err_irq_en_i,
  input  logic alert_pin_i,
  input  logic flag_clr_i,
  output logic pull_low_o,
  output logic ara_en_o,
  output logic alert_flag_o,
  output logic irq_o
);
  import alert_pkg::*;

  role_e role_w;
  logic  dev_drive_w;
  logic  host_arm_w;
  logic  pin_sync_w;
  logic  fall_w;

  always_comb begin
    role_w      = role_e'(host_mode_i);
    dev_drive_w = (role_w == ROLE_DEVICE) & alert_en_i;
    host_arm_w  = (role_w == ROLE_HOST) & alert_en_i;
  end

  alert_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (alert_pin_i),
    .q_o   (pin_sync_w)
  );

  alert_fall_det u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (host_arm_w),
    .lvl_i  (pin_sync_w),
    .fall_o (fall_w)
  );

  alert_flag_reg u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (fall_w),
    .clr_i  (flag_clr_i),
    .flag_o (alert_flag_o)
  );

  assign pull_low_o = dev_drive_w;
  assign ara_en_o   = dev_drive_w;
  assign irq_o      = alert_flag_o & err_irq_en_i;
endmodule

// File: rtl/alert_line_ctrl_chk.sv
module alert_line_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic host_mode_i,
  input logic alert_en_i,
  input logic err_irq_en_i,
  input logic flag_clr_i,
  input logic fall_evt,
  input logic pull_low_o,
  input logic ara_en_o,
  input logic alert_flag_o,
  input logic irq_o
);
  p_pull_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_en_i |-> !pull_low_o);

  p_ara_tracks_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ara_en_o == pull_low_o);

  p_flag_needs_host_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_flag_o) |-> $past(host_mode_i && alert_en_i));

  p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (alert_flag_o && err_irq_en_i));

  p_no_pull_host_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode_i |-> !pull_low_o);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_flag_o && !flag_clr_i) |=> alert_flag_o);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !fall_evt) |=> !alert_flag_o);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> alert_flag_o);
endmodule

bind alert_line_ctrl alert_line_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_mode_i  (host_mode_i),
  .alert_en_i   (alert_en_i),
  .err_irq_en_i (err_irq_en_i),
  .flag_clr_i   (flag_clr_i),
  .fall_evt     (fall_w),
  .pull_low_o   (pull_low_o),
  .ara_en_o     (ara_en_o),
  .alert_flag_o (alert_flag_o),
  .irq_o        (irq_o)
);

// File: tb/tb_alert_line_ctrl.sv
`timescale 1ns/1ps
module tb_alert_line_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic host_mode_i, alert_en_i, err_irq_en_i, alert_pin_i, flag_clr_i;
  logic pull_low_o, ara_en_o, alert_flag_o, irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 8 ns period, 125 MHz

  alert_line_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_mode_i(host_mode_i), .alert_en_i(alert_en_i),
    .err_irq_en_i(err_irq_en_i), .alert_pin_i(alert_pin_i), .flag_clr_i(flag_clr_i),
    .pull_low_o(pull_low_o), .ara_en_o(ara_en_o), .alert_flag_o(alert_flag_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b", what, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1;
    step(1);
    flag_clr_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; host_mode_i = 1'b0; alert_en_i = 1'b0; err_irq_en_i = 1'b0;
    alert_pin_i = 1'b1; flag_clr_i = 1'b0;
    step(3);
    chk("R9 pull in reset", pull_low_o, 1'b0);
    chk("R9 ara in reset", ara_en_o, 1'b0);
    chk("R9 flag in reset", alert_flag_o, 1'b0);
    chk("R9 irq in reset", irq_o, 1'b0);
    rst_n = 1'b1;
    step(2);
    chk("R9 flag after reset", alert_flag_o, 1'b0);

    // Exhaustive sweep over role, enable and interrupt enable
    for (int cfg = 0; cfg < 8; cfg++) begin
      logic m, e, i, exp_flag;
      m = cfg[2]; e = cfg[1]; i = cfg[0];
      exp_flag = m & e;
      host_mode_i = m; alert_en_i = e; err_irq_en_i = i;
      alert_pin_i = 1'b1;
      step(4);
      clear_flag();
      chk($sformatf("R1/R6 pull cfg%0d", cfg), pull_low_o, ~m & e);
      chk($sformatf("R2 ara cfg%0d", cfg), ara_en_o, ~m & e);
      alert_pin_i = 1'b0;
      step(2);
      chk($sformatf("R3 latency flag low cfg%0d", cfg), alert_flag_o, 1'b0);
      step(1);
      chk($sformatf("R3/R5 flag cfg%0d", cfg), alert_flag_o, exp_flag);
      chk($sformatf("R4 irq cfg%0d", cfg), irq_o, exp_flag & i);
      alert_pin_i = 1'b1;
      step(4);
      chk($sformatf("R7 sticky cfg%0d", cfg), alert_flag_o, exp_flag);
    end

    // R8: arm while the wire is already low
    host_mode_i = 1'b1; alert_en_i = 1'b0; err_irq_en_i = 1'b1;
    alert_pin_i = 1'b0;
    step(4);
    clear_flag();
    alert_en_i = 1'b1;
    step(4);
    chk("R8 no flag when armed on low wire", alert_flag_o, 1'b0);
    alert_pin_i = 1'b1;
    step(4);
    alert_pin_i = 1'b0;
    step(3);
    chk("R3 edge after release", alert_flag_o, 1'b1);
    chk("R4 irq after release", irq_o, 1'b1);

    // R7: clear empties the flag
    clear_flag();
    chk("R7 clear", alert_flag_o, 1'b0);
    chk("R4 irq after clear", irq_o, 1'b0);

    // R1: release in the same cycle the enable drops
    host_mode_i = 1'b0; alert_en_i = 1'b1;
    step(1);
    chk("R1 pull active", pull_low_o, 1'b1);
    alert_en_i = 1'b0;
    #1;
    chk("R1 pull released same cycle", pull_low_o, 1'b0);
    chk("R2 ara released same cycle", ara_en_o, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule